// File: doc/BRIEF.md
# Interrupt Steering Combiner

This block collects a wide set of level-sensitive interrupt requests, organised in groups of 64, and folds them into one combined request. That request is driven onto whichever of several output channel lines software has enabled. Each input can be enabled or blocked by a mask bit. Each input can also be raised by software through a set bit. Software reads status words to find which inputs are pending, and it reads a per-group summary word to narrow that search quickly. A master-disable bit silences every output line at once, and the mask, set and pending state are kept while it is set.

Software reaches the block through a simple word-addressed register port. Writes are strobed in a single cycle. A read strobe captures the addressed word into a read-data register, where it stays until the next read. The register map depends on the group count G: each bank of 2*G words is offset by a stride of G*8 bytes. The words in a bank run in reverse input order, so word 0 covers the highest-numbered 32 inputs.

Top module: `irq_funnel`

## Requirements
- R1: After reset, the channel enable, all mask words, all set words and the master-disable bit are zero, and every channel output is low.
- R2: Input k belongs to bank word 2G-1-(k/32) at bit k%32, so word 0 holds the top 32 inputs and word 2G-1 holds inputs 0 to 31.
- R3: Mask word n is read/write at byte offset 4+4n. A mask bit of 1 lets its input through, and a mask bit of 0 blocks both the input level and the set bit.
- R4: Status word n is read-only at byte offset G*16+4+4n. Each bit is (input level OR set bit) AND mask bit, and the bit drops as soon as the source level drops.
- R5: Set word n is read/write at byte offset G*8+4+4n. A set bit makes its input pending exactly as a high input level would.
- R6: The channel enable register sits at byte offset 0, with one bit per channel. Channel c is driven high one cycle after its enable bit is set and some status bit is set, and is driven low otherwise.
- R7: The master-disable register at byte offset G*24+4 (bit 0) is read/write. While it is 1, every channel output is low.
- R8: The read-only group summary at byte offset G*24+8 holds bit g set when any status bit of inputs 64g to 64g+63 is set.
- R9: A read of an unmapped or misaligned offset returns zero. A write to such an offset, or to a status or summary offset, changes nothing.
- R10: The read data register takes the addressed word at the clock edge where the read strobe is high, and holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irqIn | input | 64*GROUPS | Level interrupt requests, index k is input k |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Byte address of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| chanOut | output | CHANNELS | Combined interrupt, one line per channel |

## Verification
The hardest case to reach is the reversed word order across more than one group. The default build has a single group, which hides how the stride and the per-group summary bits scale. The bench therefore builds the block with two groups. It raises inputs at both ends of the range and at word boundaries (5, 64, 100, 127), then checks the word index and the summary bit that each input lands in. It also mixes set bits with mask bits and writes to the read-only offsets while an input is pending, to show that those writes leave the status untouched.

// File: rtl/irq_funnel_pkg.sv
package irq_funnel_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_MASK,
    SEL_SET,
    SEL_STAT,
    SEL_MDIS,
    SEL_MSTAT
  } rd_sel_e;

  typedef struct packed {
    logic    wrCtrl;
    logic    wrMask;
    logic    wrSet;
    logic    wrMdis;
    logic    rdEn;
    rd_sel_e rdSel;
  } funnel_strobe_t;

endpackage

// File: rtl/irq_funnel_decode.sv
module irq_funnel_decode
  import irq_funnel_pkg::*;
#(
  parameter int GROUPS = 1,
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 1
) (
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [ADDR_W-1:0]   busAddr,
  output funnel_strobe_t      strobe,
  output logic [IDX_W-1:0]    wordIdx
);

  localparam logic [31:0] STRIDE    = 32'(GROUPS * 8);
  localparam logic [31:0] MASK_BASE = 32'd4;
  localparam logic [31:0] SET_BASE  = STRIDE + 32'd4;
  localparam logic [31:0] STAT_BASE = 2 * STRIDE + 32'd4;
  localparam logic [31:0] MDIS_OFF  = 3 * STRIDE + 32'd4;
  localparam logic [31:0] MSTAT_OFF = 3 * STRIDE + 32'd8;

  logic [31:0] off;
  rd_sel_e     sel;

  assign off = 32'(busAddr);

  always_comb begin
    sel     = SEL_NONE;
    wordIdx = '0;
    if (off[1:0] != 2'b00) begin
      sel = SEL_NONE;
    end else if (off == 32'd0) begin
      sel = SEL_CTRL;
    end else if (off >= MASK_BASE && off < SET_BASE) begin
      sel     = SEL_MASK;
      wordIdx = IDX_W'((off - MASK_BASE) >> 2);
    end else if (off >= SET_BASE && off < STAT_BASE) begin
      sel     = SEL_SET;
      wordIdx = IDX_W'((off - SET_BASE) >> 2);
    end else if (off >= STAT_BASE && off < MDIS_OFF) begin
      sel     = SEL_STAT;
      wordIdx = IDX_W'((off - STAT_BASE) >> 2);
    end else if (off == MDIS_OFF) begin
      sel = SEL_MDIS;
    end else if (off == MSTAT_OFF) begin
      sel = SEL_MSTAT;
    end
  end

  always_comb begin
    strobe.wrCtrl = busWrEn && (sel == SEL_CTRL);
    strobe.wrMask = busWrEn && (sel == SEL_MASK);
    strobe.wrSet  = busWrEn && (sel == SEL_SET);
    strobe.wrMdis = busWrEn && (sel == SEL_MDIS);
    strobe.rdEn   = busRdEn;
    strobe.rdSel  = sel;
  end

endmodule

// File: rtl/irq_funnel_core.sv
module irq_funnel_core
  import irq_funnel_pkg::*;
#(
  parameter int GROUPS   = 1,
  parameter int CHANNELS = 4,
  parameter int IDX_W    = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [64*GROUPS-1:0]   irqIn,
  input  funnel_strobe_t         strobe,
  input  logic [IDX_W-1:0]       wordIdx,
  input  logic [31:0]            wrData,
  output logic [31:0]            rdData,
  output logic [CHANNELS-1:0]    chanOut,
  output logic [CHANNELS-1:0]    ctrlQ,
  output logic                   mdisQ,
  output logic                   anyPend,
  output logic                   maskAny
);

  localparam int NUM_IN    = 64 * GROUPS;
  localparam int NUM_WORDS = 2 * GROUPS;

  logic [31:0]        maskQ    [NUM_WORDS];
  logic [31:0]        setQ     [NUM_WORDS];
  logic [31:0]        statWord [NUM_WORDS];
  logic [NUM_IN-1:0]  statIn;
  logic [NUM_WORDS-1:0] maskNz;
  logic [GROUPS-1:0]  grpPend;
  logic [31:0]        rdMux;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlQ <= '0;
      mdisQ <= 1'b0;
      for (int w = 0; w < NUM_WORDS; w++) begin
        maskQ[w] <= '0;
        setQ[w]  <= '0;
      end
    end else begin
      if (strobe.wrCtrl) ctrlQ <= wrData[CHANNELS-1:0];
      if (strobe.wrMdis) mdisQ <= wrData[0];
      if (strobe.wrMask) maskQ[wordIdx] <= wrData;
      if (strobe.wrSet)  setQ[wordIdx]  <= wrData;
    end
  end

  // Per-word pending state, words in reverse input order
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam int LO = (NUM_WORDS - 1 - w) * 32;
    assign statWord[w]      = (irqIn[LO +: 32] | setQ[w]) & maskQ[w];
    assign statIn[LO +: 32] = statWord[w];
    assign maskNz[w]        = |maskQ[w];
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grpPend[g] = |statIn[g*64 +: 64];
  end

  assign anyPend = |grpPend;
  assign maskAny = |maskNz;

  // Channel routing
  always_ff @(posedge clk) begin
    if (rst) chanOut <= '0;
    else     chanOut <= (anyPend && !mdisQ) ? ctrlQ : '0;
  end

  // Read path
  always_comb begin
    case (strobe.rdSel)
      SEL_CTRL:  rdMux = 32'(ctrlQ);
      SEL_MASK:  rdMux = maskQ[wordIdx];
      SEL_SET:   rdMux = setQ[wordIdx];
      SEL_STAT:  rdMux = statWord[wordIdx];
      SEL_MDIS:  rdMux = {31'b0, mdisQ};
      SEL_MSTAT: rdMux = 32'(grpPend);
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)              rdData <= '0;
    else if (strobe.rdEn) rdData <= rdMux;
  end

endmodule

// File: rtl/irq_funnel.sv
module irq_funnel
  import irq_funnel_pkg::*;
#(
  parameter int GROUPS   = 1,
  parameter int CHANNELS = 4,
  parameter int ADDR_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [64*GROUPS-1:0]   irqIn,
  input  logic                   busWrEn,
  input  logic                   busRdEn,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [31:0]            busWrData,
  output logic [31:0]            busRdData,
  output logic [CHANNELS-1:0]    chanOut
);

  localparam int NUM_WORDS = 2 * GROUPS;
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  funnel_strobe_t      strobe;
  logic [IDX_W-1:0]    wordIdx;
  logic [CHANNELS-1:0] ctrlQ;
  logic                mdisQ;
  logic                anyPend;
  logic                maskAny;

  irq_funnel_decode #(
    .GROUPS(GROUPS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_decode (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .strobe  (strobe),
    .wordIdx (wordIdx)
  );

  irq_funnel_core #(
    .GROUPS(GROUPS), .CHANNELS(CHANNELS), .IDX_W(IDX_W)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .irqIn   (irqIn),
    .strobe  (strobe),
    .wordIdx (wordIdx),
    .wrData  (busWrData),
    .rdData  (busRdData),
    .chanOut (chanOut),
    .ctrlQ   (ctrlQ),
    .mdisQ   (mdisQ),
    .anyPend (anyPend),
    .maskAny (maskAny)
  );

endmodule

// File: rtl/irq_funnel_chk.sv
module irq_funnel_chk
  import irq_funnel_pkg::*;
#(
  parameter int CHANNELS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [CHANNELS-1:0] chanOut,
  input logic [CHANNELS-1:0] ctrlQ,
  input logic                mdisQ,
  input logic                anyPend,
  input logic                maskAny,
  input funnel_strobe_t      strobe,
  input logic [31:0]         busRdData
);

  AST_ROUTE_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (chanOut & ~$past(ctrlQ)) == '0); // R6

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !$past(anyPend) |-> chanOut == '0); // R6

  AST_MDIS_SILENCES: assert property (@(posedge clk) disable iff (rst)
    $past(mdisQ) |-> chanOut == '0); // R7

  AST_MASK_GATES: assert property (@(posedge clk) disable iff (rst)
    !$past(maskAny) |-> chanOut == '0); // R3

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (strobe.rdEn && strobe.rdSel == SEL_NONE) |=> busRdData == '0); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.rdEn |=> $stable(busRdData)); // R10

endmodule

bind irq_funnel irq_funnel_chk #(.CHANNELS(CHANNELS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .chanOut   (chanOut),
  .ctrlQ     (ctrlQ),
  .mdisQ     (mdisQ),
  .anyPend   (anyPend),
  .maskAny   (maskAny),
  .strobe    (strobe),
  .busRdData (busRdData)
);

// File: tb/tb_irq_funnel.sv
`timescale 1ns/1ps
module tb_irq_funnel;

  localparam int G     = 2;
  localparam int CH    = 4;
  localparam int AW    = 12;
  localparam int NIN   = 64 * G;
  localparam int NW    = 2 * G;

  logic            clk = 1'b0;
  logic            rst;
  logic [NIN-1:0]  irqIn;
  logic            busWrEn, busRdEn;
  logic [AW-1:0]   busAddr;
  logic [31:0]     busWrData;
  logic [31:0]     busRdData;
  logic [CH-1:0]   chanOut;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  irq_funnel #(.GROUPS(G), .CHANNELS(CH), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .irqIn(irqIn),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .chanOut(chanOut)
  );

  function automatic int maskOff(int n); return 4 + 4*n;        endfunction
  function automatic int setOff(int n);  return G*8 + 4 + 4*n;  endfunction
  function automatic int statOff(int n); return G*16 + 4 + 4*n; endfunction
  function automatic int mdisOff();      return G*24 + 4;       endfunction
  function automatic int mstatOff();     return G*24 + 8;       endfunction
  function automatic int wordOf(int k);  return NW - 1 - k/32;  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(int addr, logic [31:0] data);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = AW'(addr); busWrData = data;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(int addr, output logic [31:0] data);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = AW'(addr);
    @(negedge clk);
    busRdEn = 1'b0;
    data = busRdData;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clearAll();
    irqIn = '0;
    for (int n = 0; n < NW; n++) begin
      busWrite(maskOff(n), 32'hFFFF_FFFF);
      busWrite(setOff(n), 32'h0);
    end
    busWrite(0, 32'h0);
    busWrite(mdisOff(), 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 chanOut after reset", 32'(chanOut), 32'h0);
    busRead(0, d);          check("R1 ctrl", d, 32'h0);
    busRead(maskOff(0), d); check("R1 mask0", d, 32'h0);
    busRead(maskOff(3), d); check("R1 mask3", d, 32'h0);
    busRead(setOff(1), d);  check("R1 set1", d, 32'h0);
    busRead(mdisOff(), d);  check("R1 mdis", d, 32'h0);
  endtask

  task automatic t_mapping();
    logic [31:0] d;
    clearAll();
    busRead(maskOff(2), d); check("R3 mask readback", d, 32'hFFFF_FFFF);
    irqIn[5] = 1'b1; irqIn[127] = 1'b1; irqIn[64] = 1'b1;
    busRead(statOff(wordOf(5)), d);   check("R2 input5 in word3", d, 32'h0000_0020);
    busRead(statOff(wordOf(127)), d); check("R2 input127 in word0", d, 32'h8000_0000);
    busRead(statOff(wordOf(64)), d);  check("R2 input64 in word1", d, 32'h0000_0001);
    busRead(statOff(2), d);           check("R4 idle word2", d, 32'h0);
    busWrite(maskOff(3), 32'hFFFF_FFDF);
    busRead(statOff(3), d);           check("R3 masked input5", d, 32'h0);
    busWrite(maskOff(3), 32'hFFFF_FFFF);
    irqIn[127] = 1'b0;
    busRead(statOff(0), d);           check("R4 level drop clears", d, 32'h0);
  endtask

  task automatic t_set();
    logic [31:0] d;
    clearAll();
    busWrite(setOff(2), 32'h0000_0080);
    busRead(setOff(2), d);  check("R5 set readback", d, 32'h0000_0080);
    busRead(statOff(2), d); check("R5 set forces pending", d, 32'h0000_0080);
    busWrite(maskOff(2), 32'hFFFF_FF7F);
    busRead(statOff(2), d); check("R3 mask blocks set bit", d, 32'h0);
    busWrite(maskOff(2), 32'hFFFF_FFFF);
    busWrite(setOff(2), 32'h0);
    busRead(statOff(2), d); check("R5 set cleared", d, 32'h0);
  endtask

  task automatic t_route();
    clearAll();
    busWrite(0, 32'h4);
    tick();
    check("R6 no pending low", 32'(chanOut), 32'h0);
    irqIn[10] = 1'b1;
    tick();
    check("R6 channel2 routed", 32'(chanOut), 32'h4);
    irqIn[10] = 1'b0;
    tick();
    check("R6 drop after level", 32'(chanOut), 32'h0);
    busWrite(0, 32'h1);
    busWrite(setOff(0), 32'h1);
    tick();
    check("R6 channel0 via set", 32'(chanOut), 32'h1);
    busWrite(maskOff(0), 32'h0);
    tick();
    check("R3 mask silences output", 32'(chanOut), 32'h0);
  endtask

  task automatic t_mdis();
    logic [31:0] d;
    clearAll();
    busWrite(0, 32'h2);
    irqIn[40] = 1'b1;
    tick();
    check("R6 channel1 routed", 32'(chanOut), 32'h2);
    busWrite(mdisOff(), 32'h1);
    tick();
    check("R7 master disable low", 32'(chanOut), 32'h0);
    busRead(mdisOff(), d); check("R7 mdis readback", d, 32'h1);
    busWrite(mdisOff(), 32'h0);
    tick();
    check("R7 re-enabled", 32'(chanOut), 32'h2);
  endtask

  task automatic t_mstat();
    logic [31:0] d;
    clearAll();
    irqIn[5] = 1'b1;
    busRead(mstatOff(), d); check("R8 group0", d, 32'h1);
    irqIn[100] = 1'b1;
    busRead(mstatOff(), d); check("R8 both groups", d, 32'h3);
    irqIn[5] = 1'b0;
    busRead(mstatOff(), d); check("R8 group1", d, 32'h2);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    clearAll();
    irqIn[70] = 1'b1;
    busRead(mstatOff() + 4, d); check("R9 unmapped read", d, 32'h0);
    busRead(6, d);              check("R9 misaligned read", d, 32'h0);
    busWrite(statOff(wordOf(70)), 32'h0);
    busRead(statOff(wordOf(70)), d); check("R9 status write ignored", d, 32'h0000_0040);
    busWrite(mstatOff() + 4, 32'hFFFF_FFFF);
    busWrite(5, 32'hFFFF_FFFF);
    busRead(0, d);              check("R9 unmapped write ignored", d, 32'h0);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    clearAll();
    busWrite(0, 32'h9);
    busRead(0, d);
    check("R10 read value", d, 32'h9);
    busWrite(0, 32'h3);
    tick(); tick();
    check("R10 holds without read", busRdData, 32'h9);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; irqIn = '0;
    busWrEn = 1'b0; busRdEn = 1'b0; busAddr = '0; busWrData = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    t_reset();
    t_mapping();
    t_set();
    t_route();
    t_mdis();
    t_mstat();
    t_unmapped();
    t_hold();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule